// File: doc/BRIEF.md
# Receive Clock and Carrier-Sense Gating

This block sits on the receive side of a 10 Mb/s serial interface, between the clock-recovery decoder and a LAN controller. It produces the receive clock, receive data, carrier sense and collision signals that the controller samples. While the recovery loop is still settling on a new frame's preamble, the block drives a stand-in on the receive clock. With `cis` low, the stand-in copies the local transmit clock. With `cis` high, the receive clock is held low. After a fixed lock window, the block moves the receive clock over to the recovered clock. The move is made only when every clock involved is low, so that no short pulse can appear.

Carrier sense reports receive activity or a collision. For a fixed window after this node's own transmission ends, carrier sense is forced off, whatever the line state. The collision output reports a collision, and it also reports the heartbeat (SQE) test.

All inputs are synchronous levels sampled on `clk`. The recovered clock and the transmit clock arrive as oversampled levels. The timers count `tick` strobes, one per period of a 20 MHz time base. The lock window is 30 ticks (1.5 µs), which is enough for a 15-bit-time preamble lock. The inhibit window is 88 ticks (4.4 µs). Every output is registered, so it reflects the inputs of the previous clock.

Top module: `rx_clk_cs_gate`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `rx_clk_o`, `rx_data_o`, `carrier_o` and `collision_o` are all 0.
- R2: With `cis` = 0 and the recovered clock not yet selected, `rx_clk_o` equals the `tx_clk` level sampled on the previous clock.
- R3: With `cis` = 1 and the recovered clock not yet selected, `rx_clk_o` is 0.
- R4: `rx_data_o` is 0 while the recovered clock is not selected. While it is selected, `rx_data_o` loads `rec_data` on each clock where `rec_clk` was 1 at the previous sample and is 0 now. Otherwise it holds its value.
- R5: When no inhibit window is running, `carrier_o` is the OR of `crs_in` and `coll_in` from the previous clock.
- R6: A 1-to-0 change of `tx_en` starts an inhibit window of INHIBIT_TICKS (88) ticks. From the next clock until the window has been counted out, `carrier_o` is 0. A new 1-to-0 change restarts the window.
- R7: `collision_o` is the OR of `coll_in` and `sqe_in` from the previous clock. The inhibit window does not affect it.
- R8: A 0-to-1 change of `crs_in` starts a lock window of LOCK_TICKS (30) ticks. Once the window has expired, the recovered clock is selected on the first clock where `rec_clk` is 0 and either `cis` = 1 or `tx_clk` is 0. `rx_clk_o` is 0 on the clock where the selection takes effect.
- R9: When `crs_in` goes to 0, the stand-in clock returns on the next clock. The next 0-to-1 change of `crs_in` starts a fresh, full lock window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | One-clock strobe per 20 MHz time-base period |
| cis | input | 1 | Controller style: 0 = stand-in copies transmit clock, 1 = stand-in held low |
| tx_clk | input | 1 | Local transmit clock level |
| tx_en | input | 1 | Local transmission active |
| crs_in | input | 1 | Carrier detected on the selected receive input |
| rec_clk | input | 1 | Recovered clock level |
| rec_data | input | 1 | Recovered data level |
| coll_in | input | 1 | Collision present |
| sqe_in | input | 1 | Heartbeat (SQE) test active |
| rx_clk_o | output | 1 | Receive clock to the controller |
| rx_data_o | output | 1 | Receive data to the controller |
| carrier_o | output | 1 | Carrier sense to the controller |
| collision_o | output | 1 | Collision indication to the controller |

## Verification
The bench runs whole frames in both controller styles. It uses two phase offsets between the recovered clock and the transmit clock. With one offset, the switch to the recovered clock happens within a cycle of the window expiring. With the other, the switch has to wait for a common low phase, which separates the timer from the alignment rule. A carrier dropped during the lock window and then raised again shows whether the window restarts. A transmission that ends while receive carrier is already present, followed by a second transmission that ends inside the running inhibit, tests both the forcing of `carrier_o` and the restart of its window. Collision and heartbeat pulses, with and without carrier, show that `collision_o` ignores the inhibit while `carrier_o` obeys it.

// File: rtl/rxg_pkg.sv
package rxg_pkg;
  typedef enum logic [1:0] {
    RXG_IDLE  = 2'd0,
    RXG_ACQ   = 2'd1,
    RXG_ALIGN = 2'd2,
    RXG_LOCK  = 2'd3
  } rxg_state_t;
endpackage

// File: rtl/rxg_timer.sv
// Down-counter of time-base ticks; load wins over counting.
module rxg_timer #(
  parameter int unsigned COUNT = 30
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic load,
  output logic active,
  output logic active_next
);
  localparam int unsigned W = $clog2(COUNT + 1);

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_n;

  always_comb begin
    cnt_n = cnt_q;
    if (load)
      cnt_n = W'(COUNT);
    else if (tick && (cnt_q != '0))
      cnt_n = cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_q <= '0;
    else     cnt_q <= cnt_n;
  end

  assign active      = (cnt_q != '0);
  assign active_next = (cnt_n != '0);
endmodule

// File: rtl/rxg_lock_fsm.sv
// Tracks the receive clock source: stand-in, waiting out the lock window,
// waiting for a common low phase, or recovered clock.
module rxg_lock_fsm
  import rxg_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       cis,
  input  logic       crs_in,
  input  logic       crs_rise,
  input  logic       win_active,
  input  logic       tx_clk,
  input  logic       rec_clk,
  output rxg_state_t state_q,
  output rxg_state_t state_n
);
  logic both_low;
  assign both_low = !rec_clk && (cis || !tx_clk);

  always_comb begin
    state_n = state_q;
    if (!crs_in)
      state_n = RXG_IDLE;
    else if (crs_rise)
      state_n = RXG_ACQ;
    else begin
      unique case (state_q)
        RXG_ACQ:   if (!win_active) state_n = RXG_ALIGN;
        RXG_ALIGN: if (both_low)    state_n = RXG_LOCK;
        default:   state_n = state_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) state_q <= RXG_IDLE;
    else     state_q <= state_n;
  end
endmodule

// File: rtl/rxg_out.sv
// Registered controller-side outputs.
module rxg_out (
  input  logic clk,
  input  logic rst,
  input  logic cis,
  input  logic lock_n,
  input  logic tx_clk,
  input  logic rec_clk,
  input  logic rec_fall,
  input  logic rec_data,
  input  logic carrier_raw,
  input  logic inhibit_n,
  input  logic collision_raw,
  output logic rx_clk_o,
  output logic rx_data_o,
  output logic carrier_o,
  output logic collision_o
);
  logic stand_in;
  assign stand_in = !cis && tx_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_clk_o    <= 1'b0;
      rx_data_o   <= 1'b0;
      carrier_o   <= 1'b0;
      collision_o <= 1'b0;
    end else begin
      rx_clk_o    <= lock_n ? rec_clk : stand_in;
      rx_data_o   <= lock_n ? (rec_fall ? rec_data : rx_data_o) : 1'b0;
      carrier_o   <= carrier_raw && !inhibit_n;
      collision_o <= collision_raw;
    end
  end
endmodule

// File: rtl/rx_clk_cs_gate.sv
module rx_clk_cs_gate
  import rxg_pkg::*;
#(
  parameter int unsigned LOCK_TICKS    = 30,
  parameter int unsigned INHIBIT_TICKS = 88
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic cis,
  input  logic tx_clk,
  input  logic tx_en,
  input  logic crs_in,
  input  logic rec_clk,
  input  logic rec_data,
  input  logic coll_in,
  input  logic sqe_in,
  output logic rx_clk_o,
  output logic rx_data_o,
  output logic carrier_o,
  output logic collision_o
);
  logic crs_q, txen_q, rck_q;
  logic crs_rise, tx_fall, rec_fall;
  logic win_active, win_active_n;
  logic inh_active, inh_active_n;
  logic lock_q;
  rxg_state_t state_q, state_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      crs_q  <= 1'b0;
      txen_q <= 1'b0;
      rck_q  <= 1'b0;
    end else begin
      crs_q  <= crs_in;
      txen_q <= tx_en;
      rck_q  <= rec_clk;
    end
  end

  assign crs_rise = crs_in && !crs_q;
  assign tx_fall  = txen_q && !tx_en;
  assign rec_fall = rck_q && !rec_clk;
  assign lock_q   = (state_q == RXG_LOCK);

  rxg_timer #(.COUNT(LOCK_TICKS)) u_lock_win (
    .clk(clk), .rst(rst), .tick(tick), .load(crs_rise),
    .active(win_active), .active_next(win_active_n)
  );

  rxg_timer #(.COUNT(INHIBIT_TICKS)) u_inhibit (
    .clk(clk), .rst(rst), .tick(tick), .load(tx_fall),
    .active(inh_active), .active_next(inh_active_n)
  );

  rxg_lock_fsm u_fsm (
    .clk(clk), .rst(rst), .cis(cis), .crs_in(crs_in), .crs_rise(crs_rise),
    .win_active(win_active), .tx_clk(tx_clk), .rec_clk(rec_clk),
    .state_q(state_q), .state_n(state_n)
  );

  rxg_out u_out (
    .clk(clk), .rst(rst), .cis(cis),
    .lock_n(state_n == RXG_LOCK),
    .tx_clk(tx_clk), .rec_clk(rec_clk), .rec_fall(rec_fall),
    .rec_data(rec_data),
    .carrier_raw(crs_in || coll_in), .inhibit_n(inh_active_n),
    .collision_raw(coll_in || sqe_in),
    .rx_clk_o(rx_clk_o), .rx_data_o(rx_data_o),
    .carrier_o(carrier_o), .collision_o(collision_o)
  );

  logic unused_ok;
  assign unused_ok = win_active_n ^ inh_active;
endmodule

// File: rtl/rxg_checks.sv
module rxg_checks (
  input logic clk,
  input logic rst,
  input logic cis,
  input logic tx_en,
  input logic crs_in,
  input logic coll_in,
  input logic sqe_in,
  input logic locked,
  input logic rx_clk_o,
  input logic rx_data_o,
  input logic carrier_o,
  input logic collision_o
);
  p_standin_low_r3: assert property (@(posedge clk) disable iff (rst)
    (cis && !crs_in) |=> !rx_clk_o);

  p_rxd_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !crs_in |=> !rx_data_o);

  p_no_carrier_r5: assert property (@(posedge clk) disable iff (rst)
    !(crs_in || coll_in) |=> !carrier_o);

  p_inhibit_start_r6: assert property (@(posedge clk) disable iff (rst)
    $fell(tx_en) |=> !carrier_o);

  p_col_on_r7: assert property (@(posedge clk) disable iff (rst)
    (coll_in || sqe_in) |=> collision_o);

  p_col_off_r7: assert property (@(posedge clk) disable iff (rst)
    !(coll_in || sqe_in) |=> !collision_o);

  p_switch_low_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(locked) |-> !rx_clk_o);

  p_drop_unlock_r9: assert property (@(posedge clk) disable iff (rst)
    !crs_in |=> !locked);
endmodule

bind rx_clk_cs_gate rxg_checks u_chk (
  .clk(clk), .rst(rst), .cis(cis), .tx_en(tx_en), .crs_in(crs_in),
  .coll_in(coll_in), .sqe_in(sqe_in), .locked(lock_q),
  .rx_clk_o(rx_clk_o), .rx_data_o(rx_data_o),
  .carrier_o(carrier_o), .collision_o(collision_o)
);

// File: tb/tb_rx_clk_cs_gate.sv
`timescale 1ns/1ps
module tb_rx_clk_cs_gate;
  localparam int LOCK = 30;
  localparam int INH  = 88;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0, cis = 1'b0, tx_clk = 1'b0, tx_en = 1'b0;
  logic crs_in = 1'b0, rec_clk = 1'b0, rec_data = 1'b0;
  logic coll_in = 1'b0, sqe_in = 1'b0;
  logic rx_clk_o, rx_data_o, carrier_o, collision_o;

  int vectors = 0;
  int fails = 0;
  int ph = 0;
  int rphase = 2;
  bit done = 0;

  always #5 clk = ~clk;

  rx_clk_cs_gate #(.LOCK_TICKS(LOCK), .INHIBIT_TICKS(INH)) dut (
    .clk(clk), .rst(rst), .tick(tick), .cis(cis), .tx_clk(tx_clk),
    .tx_en(tx_en), .crs_in(crs_in), .rec_clk(rec_clk), .rec_data(rec_data),
    .coll_in(coll_in), .sqe_in(sqe_in), .rx_clk_o(rx_clk_o),
    .rx_data_o(rx_data_o), .carrier_o(carrier_o), .collision_o(collision_o)
  );

  // Behavioural reference: phase 0 idle, 1 lock window, 2 wait low, 3 recovered
  int m_phase = 0, m_win = 0, m_inh = 0;
  bit m_crs_q = 0, m_tx_q = 0, m_rck_q = 0;
  bit m_rxc = 0, m_rxd = 0, m_crs = 0, m_col = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_phase = 0; m_win = 0; m_inh = 0;
      m_crs_q = 0; m_tx_q = 0; m_rck_q = 0;
      m_rxc = 0; m_rxd = 0; m_crs = 0; m_col = 0;
    end else begin
      int nphase;
      int nwin;
      int ninh;
      bit rise;
      rise = crs_in && !m_crs_q;
      nphase = m_phase;
      if (!crs_in) nphase = 0;
      else if (rise) nphase = 1;
      else if (m_phase == 1 && m_win == 0) nphase = 2;
      else if (m_phase == 2 && !rec_clk && (cis || !tx_clk)) nphase = 3;
      nwin = rise ? LOCK : ((tick && m_win > 0) ? m_win - 1 : m_win);
      ninh = (m_tx_q && !tx_en) ? INH : ((tick && m_inh > 0) ? m_inh - 1 : m_inh);
      m_rxc = (nphase == 3) ? rec_clk : (!cis && tx_clk);
      if (nphase != 3) m_rxd = 0;
      else if (m_rck_q && !rec_clk) m_rxd = rec_data;
      m_crs = (crs_in || coll_in) && (ninh == 0);
      m_col = coll_in || sqe_in;
      m_phase = nphase; m_win = nwin; m_inh = ninh;
      m_crs_q = crs_in; m_tx_q = tx_en; m_rck_q = rec_clk;
    end
  end

  task automatic chk(input bit act, input bit exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s at %0t: got %0b expected %0b", tag, $time, act, exp);
    end
  endtask

  task automatic compare();
    chk(rx_clk_o,    m_rxc, cis ? "R3 R8 rx_clk_o" : "R2 R8 rx_clk_o");
    chk(rx_data_o,   m_rxd, "R4 rx_data_o");
    chk(carrier_o,   m_crs, "R5 R6 carrier_o");
    chk(collision_o, m_col, "R7 collision_o");
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      ph++;
      tx_clk   = ((ph / 5) % 2) != 0;
      rec_clk  = (((ph + rphase) / 5) % 2) != 0;
      tick     = (ph % 5) == 0;
      rec_data = $urandom_range(0, 1) != 0;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and on the first clock out of it
    chk(rx_clk_o, 1'b0, "R1 rx_clk_o"); chk(carrier_o, 1'b0, "R1 carrier_o");
    rst = 1'b0;
    @(negedge clk);
    chk(rx_clk_o, 1'b0, "R1 rx_clk_o"); chk(rx_data_o, 1'b0, "R1 rx_data_o");
    chk(carrier_o, 1'b0, "R1 carrier_o"); chk(collision_o, 1'b0, "R1 collision_o");
    run(20);
    // R2 R8: stand-in copies transmit clock, then recovered clock
    cis = 1'b0; rphase = 2; crs_in = 1'b1; run(400);
    crs_in = 1'b0; run(40);
    // R3 R8: stand-in held low
    cis = 1'b1; crs_in = 1'b1; run(400);
    crs_in = 1'b0; run(40);
    // R8: phase offset forcing a wait for common low
    cis = 1'b0; rphase = 7; crs_in = 1'b1; run(400);
    crs_in = 1'b0; run(40);
    // R9: carrier drop inside lock window, then full restart
    rphase = 3; crs_in = 1'b1; run(80);
    crs_in = 1'b0; run(3);
    crs_in = 1'b1; run(300);
    crs_in = 1'b0; run(20);
    // R6: inhibit after own transmission, restarted by a second one
    tx_en = 1'b1; crs_in = 1'b1; run(50);
    tx_en = 1'b0; run(200);
    tx_en = 1'b1; run(10);
    tx_en = 1'b0; run(500);
    crs_in = 1'b0; run(20);
    // R7 R5: collision and heartbeat, with and without inhibit
    coll_in = 1'b1; run(10); coll_in = 1'b0; run(10);
    sqe_in = 1'b1; run(10); sqe_in = 1'b0; run(10);
    tx_en = 1'b1; run(10); tx_en = 1'b0; run(5);
    coll_in = 1'b1; run(20); sqe_in = 1'b1; run(5);
    coll_in = 1'b0; sqe_in = 1'b0; run(500);
    coll_in = 1'b1; run(10); coll_in = 1'b0; run(10);
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    #2_000_000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end
endmodule